// File: doc/BRIEF.md
# Fractional bit-clock rate generator

This block derives a serial-audio bit clock from a fast base clock without needing an integer ratio between them. A rate word written by software holds a numerator X and a denominator Y. An accumulator that works modulo Y adds X on every base-clock cycle. Each time the sum reaches Y it emits an intermediate tick, so ticks arrive at base × X / Y on average. A divide-by-two stage turns those ticks into a bit-clock level with equal high and low phases, measured in ticks. Software must therefore choose X/Y so that the intermediate rate is twice the wanted bit rate. That bit rate is sample rate × 2 channels × word width in bits.

The outputs are the bit-clock level and two one-cycle strobes. The strobes mark the cycles in which the level has just risen or just fallen, which lets downstream serialisers work on the base clock as clock enables. One instance serves each transfer direction. The rate interface is a plain write strobe with a 16-bit word, with no handshake: a write is taken in the cycle its strobe is high. Every write restarts the phase from zero. Writing zero, or any ratio outside the usable range, parks the output low.

Top module: `frac_bclk_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it is sampled, `bclk`, `bclk_rise` and `bclk_fall` are low. Reset also clears the stored rate to zero, so the outputs stay low after reset until a valid rate is written.
- R2: A write takes X from `rate_wdata[15:8]` and Y from `rate_wdata[7:0]`. Count k base-clock edges after the write edge. Exactly floor(k·X/Y) intermediate ticks have been produced by edge k, and the tick produced at edge k shows on the output at edge k+1.
- R3: `bclk` inverts at every intermediate tick. After edge k (k ≥ 1) since the write edge, `bclk` equals the parity of floor((k−1)·X/Y).
- R4: `bclk_rise` is high for exactly the one cycle in which `bclk` has just changed from 0 to 1, and at no other time.
- R5: `bclk_fall` is high for exactly the one cycle in which `bclk` has just changed from 1 to 0, and at no other time.
- R6: Writing the word 0x0000 stops the generator. From the write edge on, all three outputs are low until another valid rate is written.
- R7: A ratio is usable only when 1 ≤ X ≤ Y ≤ 254. With X = 0, Y = 0, X > Y or Y = 255, no ticks are produced and all outputs stay low.
- R8: A write made while the generator is running clears the accumulator and forces `bclk` low with no strobe at the write edge. The new ratio then counts from a zero phase, so no partial pulse from the old ratio appears.
- R9: With X = Y, a tick is produced on every cycle. `bclk` then toggles on every base-clock edge from the second edge after the write on, and the rise and fall strobes alternate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_wr | input | 1 | Rate write strobe, one cycle per write |
| rate_wdata | input | 16 | Rate word: X in 15:8, Y in 7:0 |
| bclk | output | 1 | Bit-clock level |
| bclk_rise | output | 1 | One-cycle strobe, `bclk` just rose |
| bclk_fall | output | 1 | One-cycle strobe, `bclk` just fell |

## Verification
Take a write sampled at edge E0. The outputs are low after E0, and the first `bclk` toggle can come no earlier than the output of edge E2. This is because the tick is registered once in the accumulator and once more in the halving stage. The bench keeps a cycle counter k since the last write and advances it at each rising edge. From floor((k−1)·X/Y) and floor((k−2)·X/Y) it forms the expected level and strobes for the output of edge k. It compares all three outputs at the following falling edge, after the registers have settled and before the next input change.

// File: rtl/frac_bclk_pkg.sv
package frac_bclk_pkg;
  // width of one ratio field; the rate word carries two of them
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned RATE_W  = 2 * FIELD_W;
  // largest usable ratio field value (all-ones is reserved)
  localparam int unsigned MAX_FIELD = (1 << FIELD_W) - 2;

  typedef struct packed {
    logic [FIELD_W-1:0] num;
    logic [FIELD_W-1:0] den;
  } ratio_t;
endpackage

// File: rtl/frac_rate_reg.sv
module frac_rate_reg
  import frac_bclk_pkg::*;
#(
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [2*FW-1:0] wdata,
  output logic [FW-1:0] x,
  output logic [FW-1:0] y,
  output logic          usable
);
  localparam int unsigned TOP = (1 << FW) - 2;

  logic [FW-1:0] x_q, y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (wr) begin
      x_q <= wdata[2*FW-1:FW];
      y_q <= wdata[FW-1:0];
    end
  end

  // R7: usable when 1 <= X <= Y <= TOP
  always_comb begin
    usable = (x_q != '0) && (y_q != '0) && (x_q <= y_q) &&
             ({1'b0, y_q} <= (FW+1)'(TOP));
  end

  assign x = x_q;
  assign y = y_q;

  // R1: reset leaves the stored ratio unusable
  a_r1_reset_clears_ratio: assert property (@(posedge clk)
    rst |=> !usable);
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [FW-1:0] x,
  input  logic [FW-1:0] y,
  input  logic          usable,
  output logic          tick
);
  localparam int unsigned SW = FW + 1;

  logic [SW-1:0] acc_q;
  logic [SW-1:0] sum;
  logic          wrap;
  logic          tick_q;

  always_comb begin
    sum  = acc_q + SW'(x);
    wrap = (sum >= SW'(y));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= wrap ? (sum - SW'(y)) : sum;
      tick_q <= wrap;
    end
  end

  assign tick = tick_q;

  // R2: the residue always stays below the modulus while running
  a_r2_residue_below_y: assert property (@(posedge clk) disable iff (rst)
    usable |-> (acc_q < SW'(y)));

  // R7: no tick ever seen while the ratio is unusable
  a_r7_quiet_when_unusable: assert property (@(posedge clk) disable iff (rst)
    !usable |-> !tick_q);
endmodule

// File: rtl/frac_halver.sv
module frac_halver (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic level,
  output logic rise,
  output logic fall
);
  logic level_q, rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else if (tick) begin
      level_q <= ~level_q;
      rise_q  <= ~level_q;
      fall_q  <= level_q;
    end else begin
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end
  end

  assign level = level_q;
  assign rise  = rise_q;
  assign fall  = fall_q;

  // R3: every accepted tick flips the level
  a_r3_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> (level_q != $past(level_q)));

  // R4/R5: the two strobes never coincide
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise_q && fall_q));

  // R5: a fall strobe follows a cycle in which the level was high
  a_r5_fall_after_high: assert property (@(posedge clk) disable iff (rst)
    $rose(fall_q) |-> $past(level_q));
endmodule

// File: rtl/frac_bclk_gen.sv
module frac_bclk_gen
  import frac_bclk_pkg::*;
#(
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate_wr,
  input  logic [2*FW-1:0] rate_wdata,
  output logic          bclk,
  output logic          bclk_rise,
  output logic          bclk_fall
);
  logic [FW-1:0] x, y;
  logic          usable;
  logic          clr;
  logic          tick;

  frac_rate_reg #(.FW(FW)) u_rate (
    .clk(clk), .rst(rst), .wr(rate_wr), .wdata(rate_wdata),
    .x(x), .y(y), .usable(usable)
  );

  // a write restarts the phase; an unusable ratio holds everything clear
  assign clr = rate_wr | ~usable;

  frac_accum #(.FW(FW)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .x(x), .y(y),
    .usable(usable), .tick(tick)
  );

  frac_halver u_half (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick),
    .level(bclk), .rise(bclk_rise), .fall(bclk_fall)
  );

  // R8: a write leaves the outputs low and quiet at its edge
  a_r8_clear_on_write: assert property (@(posedge clk) disable iff (rst)
    rate_wr |=> (!bclk && !bclk_rise && !bclk_fall));

  // R6: writing zero stops the clock
  a_r6_zero_stops: assert property (@(posedge clk) disable iff (rst)
    (rate_wr && rate_wdata == '0) |=> !bclk);

  // R1: reset drives the outputs low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!bclk && !bclk_rise && !bclk_fall));
endmodule

// File: tb/frac_bclk_gen_tb.sv
module frac_bclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rate_wr = 1'b0;
  logic [15:0] rate_wdata = 16'h0000;
  logic        bclk, bclk_rise, bclk_fall;

  frac_bclk_gen u_dut (
    .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string req    = "R1";
  int    mx = 0, my = 0, k = 0;
  bit    done = 1'b0;

  function automatic bit m_usable();
    return (mx >= 1) && (my >= 1) && (my <= 254) && (mx <= my);
  endfunction

  // parity of ticks produced in n cycles from a zero phase
  function automatic bit m_par(int n);
    return bit'(((n * mx) / my) % 2);
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      mx = 0; my = 0; k = 0;
    end else if (rate_wr) begin
      mx = int'(rate_wdata[15:8]);
      my = int'(rate_wdata[7:0]);
      k  = 0;
    end else if (m_usable()) begin
      k = k + 1;
    end else begin
      k = 0;
    end
  end

  task automatic check(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b k=%0d X=%0d Y=%0d",
               tag, name, act, exp, k, mx, my);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit eb, ep;
      eb = (m_usable() && k >= 1) ? m_par(k - 1) : 1'b0;
      ep = (m_usable() && k >= 2) ? m_par(k - 2) : 1'b0;
      check(req, "bclk(R3)",      bclk,      eb);
      check(req, "bclk_rise(R4)", bclk_rise, eb & ~ep);
      check(req, "bclk_fall(R5)", bclk_fall, ~eb & ep);
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic write_rate(int xv, int yv, int run);
    @(negedge clk); #1;
    rate_wr    = 1'b1;
    rate_wdata = {8'(xv), 8'(yv)};
    @(negedge clk); #1;
    rate_wr    = 1'b0;
    repeat (run) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    req = "R1";
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    repeat (10) @(negedge clk);
    req = "R2"; write_rate(3, 7, 300);
    req = "R9"; write_rate(5, 5, 60);
    req = "R2"; write_rate(1, 254, 1100);
    req = "R9"; write_rate(254, 254, 40);
    req = "R3"; write_rate(7, 16, 250);
    req = "R8"; write_rate(2, 9, 13);
    req = "R8"; write_rate(4, 9, 200);
    req = "R8"; write_rate(5, 5, 3);
    req = "R8"; write_rate(1, 3, 120);
    req = "R7"; write_rate(0, 5, 30);
    req = "R7"; write_rate(6, 5, 30);
    req = "R7"; write_rate(255, 255, 30);
    req = "R7"; write_rate(3, 0, 30);
    req = "R7"; write_rate(7, 255, 30);
    req = "R3"; write_rate(3, 7, 50);
    req = "R6"; write_rate(0, 0, 40);
    req = "R1"; write_rate(1, 2, 30);
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    repeat (20) @(negedge clk);
    finish_up();
  end
endmodule